// File: doc/BRIEF.md
# Partitioned Pixel-by-Coefficient Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit coefficients in parallel lanes, which is the inner step of scaling, blending and filtering packed image data. Every cycle it can accept a pair of 64-bit operands together with a 9-bit operation selector. The selector picks which bytes of the first operand and which 16-bit fields of the second operand feed each lane, and how the lane products are packed into the 64-bit result.

There are two result formats. In the four-lane formats, each lane keeps the middle sixteen bits of its 24-bit product and rounds half up. In the two-lane formats, the full signed product of each lane, shifted left by eight bits, fills a 32-bit slot. The datapath has a multiply stage and a round-and-pack stage, so each result appears two cycles after its operands, and a new operation can start on every cycle.

Top module: `pmul8x16`

## Requirements
- R1: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` is high, and low otherwise. The `out_data` shown with it belongs to that operation.
- R2: While `rst_n` is low, `out_valid` and `out_data` are zero, and any `in_valid` pulses during that time produce no result.
- R3: While `out_valid` is low, `out_data` holds its last value.
- R4: Each four-lane result is the 24-bit two's-complement product of an unsigned byte and a signed 16-bit coefficient. The lane value is product bits [23:8], plus one when product bit 7 is set, taken modulo 2^16. Lane i occupies `out_data[16i+15:16i]`.
- R5: Selector 0x031: lane i multiplies `in_a[8i+7:8i]` by `in_b[16i+15:16i]`, for i = 0 to 3.
- R6: Selector 0x033: lane i multiplies `in_a[8i+7:8i]` by the shared coefficient `in_b[31:16]`.
- R7: Selector 0x035: lane i multiplies `in_a[8i+7:8i]` by the shared coefficient `in_b[15:0]`.
- R8: Selector 0x036: lane i multiplies `in_a[16i+15:16i+8]` by `in_b[16i+15:16i]`.
- R9: Selector 0x037: lane i multiplies `in_a[16i+7:16i]` by `in_b[16i+15:16i]`.
- R10: Selectors 0x038 and 0x039 form two products, for i = 0 and 1. The byte is `in_a[16i+15:16i+8]` for 0x038 and `in_a[16i+7:16i]` for 0x039, and the coefficient is `in_b[16i+15:16i]`. Each product goes to `out_data[32i+31:32i]` as its 24-bit signed value followed by eight zero bits, with no rounding.
- R11: Any other selector value gives a result of all zeros, with `out_valid` still following R1.
- R12: Operations presented on consecutive cycles each produce their own correct result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and selector are present this cycle |
| in_op | input | 9 | Operation selector |
| in_a | input | 64 | Pixel byte operand |
| in_b | input | 64 | Coefficient operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Packed lane results |

## Verification
Several properties are checked on every cycle. These are the two-cycle valid latency, the holding of the output between results, the zero low byte in both slots of the two-lane formats, the all-zero result for an unrecognised selector, equal lanes for a shared coefficient applied to equal bytes, and a zero lane whenever one of its factors is zero. The exact arithmetic cannot be shown by these properties. This includes the middle-bit selection, the half-up increment, sign handling for negative coefficients, and the byte and coefficient routing for each selector. Those can only be shown by the bench's scoreboard, using hand-worked vectors, a sweep over every selector with mixed signs, and an unbroken stream that tests ordering.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  localparam int OPC_W = 9;

  localparam logic [OPC_W-1:0] OPC_PLAIN    = 9'h031;
  localparam logic [OPC_W-1:0] OPC_SPLAT_HI = 9'h033;
  localparam logic [OPC_W-1:0] OPC_SPLAT_LO = 9'h035;
  localparam logic [OPC_W-1:0] OPC_HALF_HI  = 9'h036;
  localparam logic [OPC_W-1:0] OPC_HALF_LO  = 9'h037;
  localparam logic [OPC_W-1:0] OPC_PAIR_HI  = 9'h038;
  localparam logic [OPC_W-1:0] OPC_PAIR_LO  = 9'h039;

  // result packing chosen by the selector
  typedef enum logic [1:0] {
    FMT_ZERO = 2'd0,
    FMT_QUAD = 2'd1,
    FMT_PAIR = 2'd2
  } fmt_e;

  // where each lane's pixel byte comes from
  typedef enum logic [1:0] {
    BSRC_NONE   = 2'd0,
    BSRC_PACKED = 2'd1,
    BSRC_UPPER  = 2'd2,
    BSRC_LOWER  = 2'd3
  } bsrc_e;

  // where each lane's coefficient comes from
  typedef enum logic [1:0] {
    CSRC_LANE   = 2'd0,
    CSRC_BCAST1 = 2'd1,
    CSRC_BCAST0 = 2'd2
  } csrc_e;

endpackage

// File: rtl/pmul_opsel.sv
module pmul_opsel
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16,
  localparam int DATA_W = LANES * COEF_W
) (
  input  logic [OPC_W-1:0]              op,
  input  logic [DATA_W-1:0]             src_a,
  input  logic [DATA_W-1:0]             src_b,
  output fmt_e                          fmt,
  output logic [LANES-1:0][BYTE_W-1:0]  lane_byte,
  output logic [LANES-1:0][COEF_W-1:0]  lane_coef
);

  localparam int PAIR_LANES = LANES / 2;

  bsrc_e bsrc;
  csrc_e csrc;

  // selector decode
  always_comb begin
    fmt  = FMT_ZERO;
    bsrc = BSRC_NONE;
    csrc = CSRC_LANE;
    case (op)
      OPC_PLAIN:    begin fmt = FMT_QUAD; bsrc = BSRC_PACKED; end
      OPC_SPLAT_HI: begin fmt = FMT_QUAD; bsrc = BSRC_PACKED; csrc = CSRC_BCAST1; end
      OPC_SPLAT_LO: begin fmt = FMT_QUAD; bsrc = BSRC_PACKED; csrc = CSRC_BCAST0; end
      OPC_HALF_HI:  begin fmt = FMT_QUAD; bsrc = BSRC_UPPER; end
      OPC_HALF_LO:  begin fmt = FMT_QUAD; bsrc = BSRC_LOWER; end
      OPC_PAIR_HI:  begin fmt = FMT_PAIR; bsrc = BSRC_UPPER; end
      OPC_PAIR_LO:  begin fmt = FMT_PAIR; bsrc = BSRC_LOWER; end
      default:      begin fmt = FMT_ZERO; bsrc = BSRC_NONE; end
    endcase
  end

  // per-lane operand routing
  for (genvar i = 0; i < LANES; i++) begin : g_route
    localparam bit IN_PAIR = (i < PAIR_LANES);

    logic lane_on;

    assign lane_on = (fmt == FMT_QUAD) || ((fmt == FMT_PAIR) && IN_PAIR);

    always_comb begin
      lane_byte[i] = '0;
      if (lane_on) begin
        case (bsrc)
          BSRC_PACKED: lane_byte[i] = src_a[i*BYTE_W +: BYTE_W];
          BSRC_UPPER:  lane_byte[i] = src_a[i*COEF_W + BYTE_W +: BYTE_W];
          BSRC_LOWER:  lane_byte[i] = src_a[i*COEF_W +: BYTE_W];
          default:     lane_byte[i] = '0;
        endcase
      end
    end

    always_comb begin
      case (csrc)
        CSRC_BCAST1: lane_coef[i] = src_b[COEF_W +: COEF_W];
        CSRC_BCAST0: lane_coef[i] = src_b[0 +: COEF_W];
        default:     lane_coef[i] = src_b[i*COEF_W +: COEF_W];
      endcase
    end
  end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = BYTE_W + COEF_W
) (
  input  logic [BYTE_W-1:0] pix,
  input  logic [COEF_W-1:0] coef,
  output logic [PROD_W-1:0] prod
);

  logic [PROD_W-1:0] pix_ext;
  logic [PROD_W-1:0] coef_ext;

  // unsigned byte widened with zeros, coefficient widened with its sign;
  // the true product fits the width, so the truncated product is exact
  assign pix_ext  = {{(PROD_W-BYTE_W){1'b0}}, pix};
  assign coef_ext = {{(PROD_W-COEF_W){coef[COEF_W-1]}}, coef};
  assign prod     = pix_ext * coef_ext;

endmodule

// File: rtl/pmul_pack.sv
module pmul_pack
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = BYTE_W + COEF_W,
  localparam int DATA_W = LANES * COEF_W,
  localparam int SLOT_W = 2 * COEF_W,
  localparam int PAIR_LANES = LANES / 2
) (
  input  fmt_e                          fmt,
  input  logic [LANES-1:0][PROD_W-1:0]  prod,
  output logic [DATA_W-1:0]             word
);

  logic [LANES-1:0][COEF_W-1:0]      quad_w;
  logic [PAIR_LANES-1:0][SLOT_W-1:0] pair_w;

  // four-lane format: middle bits, plus the half-up increment
  for (genvar i = 0; i < LANES; i++) begin : g_round
    assign quad_w[i] = prod[i][PROD_W-1:BYTE_W]
                     + {{(COEF_W-1){1'b0}}, prod[i][BYTE_W-1]};
  end

  // two-lane format: the routing leaves the upper lanes at zero in this
  // format, so each slot merges lane j with its idle partner
  for (genvar j = 0; j < PAIR_LANES; j++) begin : g_slot
    logic [PROD_W-1:0] merged;
    assign merged    = prod[j] | prod[j + PAIR_LANES];
    assign pair_w[j] = {merged, {(SLOT_W-PROD_W){1'b0}}};
  end

  always_comb begin
    case (fmt)
      FMT_QUAD: word = quad_w;
      FMT_PAIR: word = pair_w;
      default:  word = '0;
    endcase
  end

endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = BYTE_W + COEF_W,
  localparam int DATA_W = LANES * COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  fmt_e                          fmt_c;
  logic [LANES-1:0][BYTE_W-1:0]  byte_c;
  logic [LANES-1:0][COEF_W-1:0]  coef_c;
  logic [LANES-1:0][PROD_W-1:0]  prod_c;

  // stage 1 state: products and packing format
  logic                          s1_valid_q, s1_valid_d;
  fmt_e                          s1_fmt_q, s1_fmt_d;
  logic [LANES-1:0][PROD_W-1:0]  s1_prod_q, s1_prod_d;

  // stage 2 state: packed result
  logic                          s2_valid_q, s2_valid_d;
  logic [DATA_W-1:0]             s2_data_q, s2_data_d;
  logic [DATA_W-1:0]             pack_c;

  pmul_opsel #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W),
    .COEF_W (COEF_W)
  ) u_opsel (
    .op        (in_op),
    .src_a     (in_a),
    .src_b     (in_b),
    .fmt       (fmt_c),
    .lane_byte (byte_c),
    .lane_coef (coef_c)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmul_lane #(
      .BYTE_W (BYTE_W),
      .COEF_W (COEF_W)
    ) u_lane (
      .pix  (byte_c[i]),
      .coef (coef_c[i]),
      .prod (prod_c[i])
    );
  end

  // stage 1 next state, loaded only when an operation arrives
  always_comb begin
    s1_valid_d = in_valid;
    s1_fmt_d   = s1_fmt_q;
    s1_prod_d  = s1_prod_q;
    if (in_valid) begin
      s1_fmt_d  = fmt_c;
      s1_prod_d = prod_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_fmt_q   <= FMT_ZERO;
      s1_prod_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_fmt_q   <= s1_fmt_d;
      s1_prod_q  <= s1_prod_d;
    end
  end

  pmul_pack #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W),
    .COEF_W (COEF_W)
  ) u_pack (
    .fmt  (s1_fmt_q),
    .prod (s1_prod_q),
    .word (pack_c)
  );

  // stage 2 next state, result held between operations
  always_comb begin
    s2_valid_d = s1_valid_q;
    s2_data_d  = s2_data_q;
    if (s1_valid_q) begin
      s2_data_d = pack_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid_q <= 1'b0;
      s2_data_q  <= '0;
    end else begin
      s2_valid_q <= s2_valid_d;
      s2_data_q  <= s2_data_d;
    end
  end

  assign out_valid = s2_valid_q;
  assign out_data  = s2_data_q;

endmodule

// File: rtl/pmul8x16_chk.sv
module pmul8x16_chk
  import pmul_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OPC_W-1:0]  in_op,
  input logic [31:0]       a_lo,
  input logic [15:0]       b_lo,
  input logic              out_valid,
  input logic [63:0]       out_data
);

  logic known_op;
  logic pair_op;
  logic splat_op;
  logic bytes_equal;

  assign pair_op  = (in_op == OPC_PAIR_HI) || (in_op == OPC_PAIR_LO);
  assign splat_op = (in_op == OPC_SPLAT_HI) || (in_op == OPC_SPLAT_LO);
  assign known_op = pair_op || splat_op || (in_op == OPC_PLAIN)
                  || (in_op == OPC_HALF_HI) || (in_op == OPC_HALF_LO);
  assign bytes_equal = (a_lo[7:0] == a_lo[15:8]) && (a_lo[7:0] == a_lo[23:16])
                     && (a_lo[7:0] == a_lo[31:24]);

  // R2: outputs cleared while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R2: assert (!out_valid && out_data == 64'd0);
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  assert_pair_low_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_op) |-> ##2 (out_data[7:0] == 8'd0 && out_data[39:32] == 8'd0));

  assert_unknown_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !known_op) |-> ##2 (out_data == 64'd0));

  // R6 and R7: a shared coefficient on equal bytes yields equal lanes
  assert_splat_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && splat_op && bytes_equal) |->
      ##2 (out_data[15:0] == out_data[31:16] && out_data[15:0] == out_data[47:32]
           && out_data[15:0] == out_data[63:48]));

  assert_zero_factor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OPC_PLAIN && (a_lo[7:0] == 8'd0 || b_lo == 16'd0)) |->
      ##2 (out_data[15:0] == 16'd0));

endmodule

bind pmul8x16 pmul8x16_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .a_lo      (in_a[31:0]),
  .b_lo      (in_b[15:0]),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/pmul8x16_tb.sv
module pmul8x16_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [8:0]  in_op;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic        out_valid;
  logic [63:0] out_data;

  typedef struct {
    logic [63:0] data;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk;
  int          n_fail;
  int          cyc;
  logic [63:0] last_out;
  bit          have_last;
  bit          done;

  pmul8x16 u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference for the selector set
  function automatic logic [63:0] model(input logic [8:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    logic [31:0] pu;
    int          byt;
    int          cf;
    int          p;
    r = '0;
    case (op)
      9'h031, 9'h033, 9'h035, 9'h036, 9'h037: begin
        for (int i = 0; i < 4; i++) begin
          if (op == 9'h036)      byt = int'(a[16*i+8 +: 8]);
          else if (op == 9'h037) byt = int'(a[16*i +: 8]);
          else                   byt = int'(a[8*i +: 8]);
          if (op == 9'h033)      cf = int'($signed(b[31:16]));
          else if (op == 9'h035) cf = int'($signed(b[15:0]));
          else                   cf = int'($signed(b[16*i +: 16]));
          p  = byt * cf;
          pu = p;
          r[16*i +: 16] = pu[23:8] + {15'd0, pu[7]};
        end
      end
      9'h038, 9'h039: begin
        for (int i = 0; i < 2; i++) begin
          if (op == 9'h038) byt = int'(a[16*i+8 +: 8]);
          else              byt = int'(a[16*i +: 8]);
          cf = int'($signed(b[16*i +: 16]));
          p  = byt * cf;
          pu = p;
          r[32*i +: 32] = {pu[23:0], 8'h00};
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic drive_exp(input logic [8:0] op, input logic [63:0] a,
                           input logic [63:0] b, input logic [63:0] exp,
                           input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_a     = a;
    in_b     = b;
    e.data   = exp;
    e.cyc    = cyc;
    e.tag    = tag;
    sb.push_back(e);
  endtask

  task automatic drive(input logic [8:0] op, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    drive_exp(op, a, b, model(op, a, b), tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op    = $urandom_range(0, 511);
      in_a     = {$urandom, $urandom};
      in_b     = {$urandom, $urandom};
    end
  endtask

  // monitor: pop and compare as results emerge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R1 unexpected result", out_data, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(out_data === e.data, e.tag, out_data, e.data);
          chk(cyc == e.cyc + 2, "R1 latency", 64'(cyc), 64'(e.cyc + 2));
        end
        last_out  = out_data;
        have_last = 1'b1;
      end else if (have_last) begin
        chk(out_data === last_out, "R3 hold", out_data, last_out);
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  logic [8:0] op_list [9];

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    have_last = 1'b0;
    done      = 1'b0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_op     = '0;
    in_a      = '0;
    in_b      = '0;
    op_list   = '{9'h031, 9'h033, 9'h035, 9'h036, 9'h037, 9'h038, 9'h039,
                  9'h032, 9'h000};

    // R2: pulses during reset are dropped and the outputs stay clear
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = 9'h031;
      in_a     = 64'hffff_ffff_ffff_ffff;
      in_b     = 64'h7fff_7fff_7fff_7fff;
      chk(out_valid == 1'b0 && out_data == 64'd0, "R2 reset",
          {63'd0, out_valid} | out_data, 64'd0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    idle(3);
    chk(out_valid == 1'b0 && out_data == 64'd0, "R2 reset drops pulses",
        {63'd0, out_valid} | out_data, 64'd0);

    // R4 hand-worked lanes: round-up, middle bits, negative product, zero byte
    drive_exp(9'h031, 64'h0000_0000_00ff_8001, 64'h1234_ffff_0100_0080,
              64'h0000_ffff_0080_0001, "R4 hand lanes");
    // R10 hand-worked: 0x02 * -1 = 0xfffffe, shifted by eight
    drive_exp(9'h039, 64'h0000_0000_0003_0002, 64'h0000_0000_0010_ffff,
              64'h0000_3000_ffff_fe00, "R10 hand pair");
    idle(3);

    drive(9'h031, 64'h0000_0000_80ff_407f, 64'h8000_7fff_c000_0101, "R5 plain");
    drive(9'h031, 64'h0000_0000_ffff_ffff, 64'h8000_8000_8000_8000, "R5 plain extremes");
    drive(9'h033, 64'h0000_0000_1080_ff01, 64'h1111_2222_fe80_3333, "R6 bcast upper");
    drive(9'h035, 64'h0000_0000_1080_ff01, 64'h1111_2222_4444_8001, "R7 bcast lower");
    drive(9'h036, 64'hff00_8011_01fe_7f7f, 64'h8000_1234_ffff_0180, "R8 upper bytes");
    drive(9'h037, 64'hff00_8011_01fe_7f7f, 64'h8000_1234_ffff_0180, "R9 lower bytes");
    drive(9'h038, 64'hdead_beef_ff00_7f00, 64'hffff_ffff_8000_7fff, "R10 pair upper");
    drive(9'h039, 64'hdead_beef_00ff_007f, 64'hffff_ffff_8000_7fff, "R10 pair lower");
    drive(9'h032, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, "R11 unknown");
    drive(9'h1ff, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, "R11 unknown high");
    idle(4);

    // R12: unbroken stream over every selector and random data
    for (int k = 0; k < 150; k++) begin
      drive(op_list[$urandom_range(0, 8)], {$urandom, $urandom}, {$urandom, $urandom},
            "R12 stream");
    end
    idle(2);
    for (int k = 0; k < 60; k++) begin
      drive(op_list[$urandom_range(0, 6)], {$urandom, $urandom}, {$urandom, $urandom},
            "R12 gapped");
      if (k % 3 == 0) idle(1);
    end
    idle(6);

    chk(sb.size() == 0, "R1 all results seen", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule